// File: doc/BRIEF.md
# Serial 12-bit Port Expander

This block adds twelve open-drain port pins to a host that has only a few serial wires. The host uses a select line, a shift clock, a data input and a data output. When the host pulls select low, the block captures the current level of every pin. It then returns those levels one per shift clock. In the same frame it takes in a new 12-bit word. When select is released, that word goes into the output latch that drives the pins.

A pin whose latch bit is 0 is pulled low. A pin whose latch bit is 1 is released, so it can be used as an input. The captured readback is the pin level ANDed with the latch bit.

A frame lasts twelve clocks. Clocks beyond the twelfth are ignored. If select is released early, the latch takes the incoming register as it stands at that moment. The frame still runs to its twelfth clock.

A separate enable input floats the serial output and all pins while it is low. All host signals are sampled in a faster system clock domain, and their edges are found there.

Top module: `spx_expander`

## Requirements
- R1: After reset the output latch holds all ones, no pin is driven low and the serial output is not enabled.
- R2: On a falling edge of `host_sel_n`, the block captures the word `pin_in & latch` for readback.
- R3: The n-th falling edge of `host_sclk` in a frame drives captured bit n-1 onto `host_miso`, with `host_miso_oe` high. Bit 0 goes out first.
- R4: Each rising edge of `host_sclk` shifts `host_mosi` into the top of the incoming 12-bit register, and the register moves towards bit 0. A rising edge of `host_sel_n` copies that register into the latch. `pin_drive_low` is then the inverse of the latch. After a full frame, the first bit received lands in port bit 0.
- R5: Shift clock edges after the 12th rising edge of a frame are ignored. No further data is shifted, and `host_miso_oe` is low.
- R6: If `host_sel_n` rises after k<12 bits, the latch takes the incoming register as it holds then. In that value, the top k bits are the received bits and the rest are the previous contents shifted down by k. Readback bits keep coming out until the 12th clock.
- R7: While `port_en` is low, `host_miso_oe` and every `pin_drive_low` bit are 0, at once and without a clock. The latch keeps its value and reappears when `port_en` returns high.
- R8: `host_miso_oe` is low whenever no frame is running, and also after select falls but before the first falling shift clock edge.
- R9: A falling edge of select while a frame is still running restarts the bit count. It also reloads the readback register, so the next bit out is captured bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock used to sample all host signals |
| sys_rst_n | input | 1 | Asynchronous active-low reset |
| host_sclk | input | 1 | Host shift clock, idle high |
| host_sel_n | input | 1 | Host select, active low |
| host_mosi | input | 1 | Serial data from the host |
| port_en | input | 1 | Output enable; low floats the serial output and all pins |
| pin_in | input | 12 | Sampled level of each port pin |
| host_miso | output | 1 | Serial readback data |
| host_miso_oe | output | 1 | Drive enable for `host_miso` |
| pin_drive_low | output | 12 | Per-pin pull-low enable (open drain) |

## Verification
The checker watches several rules on every cycle. The enable input must float every output. The serial output may be enabled only inside a running frame. The bit count must stay within twelve. The latch may change only after a select release. A select fall must start a frame, and the twelfth rising edge must end it. Other behaviour depends on the sequence of data and needs the bench's scenarios. This covers the order of bits on the serial output, the wired-AND readback, the mixed value latched by an early release, the clocks ignored after the twelfth, and the restart of an unfinished frame.

// File: rtl/spx_pkg.sv
package spx_pkg;
   typedef struct packed {
      logic rise;
      logic fall;
   } spx_edge_t;

   function automatic int spx_cnt_w(input int width);
      return $clog2(width + 1);
   endfunction
endpackage

// File: rtl/spx_sync.sv
module spx_sync #(
   parameter int          N       = 1,
   parameter int          STAGES  = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spx_sync: STAGES must be at least 2");
      end
      if (N < 1) begin : g_bad_n
         $error("spx_sync: N must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][N-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spx_edge.sv
module spx_edge
   import spx_pkg::*;
#(
   parameter int           N       = 1,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         lvl,
   output spx_edge_t [N-1:0]    ev
);
   logic [N-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= lvl;
   end

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         assign ev[i].rise = lvl[i] & ~prev[i];
         assign ev[i].fall = ~lvl[i] & prev[i];
      end
   endgenerate
endmodule

// File: rtl/spx_frame.sv
module spx_frame #(
   parameter int W = 12
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic                        shift_out,
   input  logic                        shift_in,
   input  logic                        sdi,
   input  logic [W-1:0]                load_word,
   output logic [W-1:0]                in_word,
   output logic                        sdo_bit,
   output logic                        sdo_live,
   output logic                        running,
   output logic [spx_pkg::spx_cnt_w(W)-1:0] bit_cnt
);
   localparam int CW = spx_pkg::spx_cnt_w(W);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   generate
      if (W < 2) begin : g_bad_w
         $error("spx_frame: W must be at least 2");
      end
   endgenerate

   logic [W-1:0]  out_sr;
   logic [W-1:0]  in_sr;
   logic [CW-1:0] cnt;
   logic          run;
   logic          shown;
   logic          sdo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_sr <= '0;
         in_sr  <= '0;
         cnt    <= '0;
         run    <= 1'b0;
         shown  <= 1'b0;
         sdo_q  <= 1'b1;
      end else if (start) begin
         out_sr <= load_word;
         cnt    <= '0;
         run    <= 1'b1;
         shown  <= 1'b0;
      end else if (run) begin
         if (shift_out) begin
            sdo_q  <= out_sr[0];
            out_sr <= {1'b0, out_sr[W-1:1]};
            shown  <= 1'b1;
         end
         if (shift_in) begin
            in_sr <= {sdi, in_sr[W-1:1]};
            cnt   <= cnt + CW'(1);
            if (cnt == LAST) run <= 1'b0;
         end
      end
   end

   assign in_word  = in_sr;
   assign sdo_bit  = sdo_q;
   assign sdo_live = run & shown;
   assign running  = run;
   assign bit_cnt  = cnt;
endmodule

// File: rtl/spx_port.sv
module spx_port #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         commit,
   input  logic [W-1:0] new_word,
   input  logic         en,
   input  logic [W-1:0] pin_in,
   output logic [W-1:0] latch_q,
   output logic [W-1:0] cap,
   output logic [W-1:0] drive_low
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_pin
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      bit_q <= 1'b1;
            else if (commit) bit_q <= new_word[i];
         end
         assign latch_q[i]   = bit_q;
         assign cap[i]       = pin_in[i] & bit_q;
         assign drive_low[i] = en & ~bit_q;
      end
   endgenerate
endmodule

// File: rtl/spx_expander.sv
module spx_expander
   import spx_pkg::*;
#(
   parameter int W           = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic         sys_clk,
   input  logic         sys_rst_n,
   input  logic         host_sclk,
   input  logic         host_sel_n,
   input  logic         host_mosi,
   input  logic         port_en,
   input  logic [W-1:0] pin_in,
   output logic         host_miso,
   output logic         host_miso_oe,
   output logic [W-1:0] pin_drive_low
);
   localparam int CW = spx_cnt_w(W);
   localparam int CTL_N = 2;
   localparam int IDX_SCLK = 0;
   localparam int IDX_SEL  = 1;

   logic [CTL_N-1:0]      ctl_raw;
   logic [CTL_N-1:0]      ctl_s;
   spx_edge_t [CTL_N-1:0] ctl_ev;
   logic                  mosi_s;
   logic                  cs_fall;
   logic                  cs_rise;
   logic [W-1:0]          cap_word;
   logic [W-1:0]          in_word;
   logic [W-1:0]          latch_q;
   logic                  sdo_live;
   logic                  frame_run;
   logic [CW-1:0]         frame_cnt;

   assign ctl_raw[IDX_SCLK] = host_sclk;
   assign ctl_raw[IDX_SEL]  = host_sel_n;

   spx_sync #(.N(CTL_N), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_ctl_sync (
      .clk(sys_clk), .rst_n(sys_rst_n), .d(ctl_raw), .q(ctl_s));

   spx_sync #(.N(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_dat_sync (
      .clk(sys_clk), .rst_n(sys_rst_n), .d(host_mosi), .q(mosi_s));

   spx_edge #(.N(CTL_N), .RST_VAL(2'b11)) u_edge (
      .clk(sys_clk), .rst_n(sys_rst_n), .lvl(ctl_s), .ev(ctl_ev));

   assign cs_fall = ctl_ev[IDX_SEL].fall;
   assign cs_rise = ctl_ev[IDX_SEL].rise;

   spx_frame #(.W(W)) u_frame (
      .clk(sys_clk), .rst_n(sys_rst_n),
      .start(cs_fall),
      .shift_out(ctl_ev[IDX_SCLK].fall),
      .shift_in(ctl_ev[IDX_SCLK].rise),
      .sdi(mosi_s),
      .load_word(cap_word),
      .in_word(in_word),
      .sdo_bit(host_miso),
      .sdo_live(sdo_live),
      .running(frame_run),
      .bit_cnt(frame_cnt));

   spx_port #(.W(W)) u_port (
      .clk(sys_clk), .rst_n(sys_rst_n),
      .commit(cs_rise),
      .new_word(in_word),
      .en(port_en),
      .pin_in(pin_in),
      .latch_q(latch_q),
      .cap(cap_word),
      .drive_low(pin_drive_low));

   assign host_miso_oe = sdo_live & port_en;
endmodule

// File: rtl/spx_checker.sv
module spx_checker #(
   parameter int W  = 12,
   parameter int CW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          port_en,
   input logic          miso_oe,
   input logic [W-1:0]  drive_low,
   input logic [W-1:0]  latch_q,
   input logic          cs_fall,
   input logic          cs_rise,
   input logic          shift_in,
   input logic          run,
   input logic [CW-1:0] cnt
);
   assert_float_on_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |-> (!miso_oe && drive_low == '0));

   assert_oe_inside_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
      miso_oe |-> run);

   assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(W));

   assert_latch_on_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q != $past(latch_q)) |-> $past(cs_rise));

   assert_frame_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |=> (run && cnt == '0));

   assert_frame_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && shift_in && !cs_fall && cnt == CW'(W - 1)) |=> !run);
endmodule

bind spx_expander spx_checker #(.W(W), .CW(CW)) u_chk (
   .clk(sys_clk), .rst_n(sys_rst_n), .port_en(port_en),
   .miso_oe(host_miso_oe), .drive_low(pin_drive_low), .latch_q(latch_q),
   .cs_fall(cs_fall), .cs_rise(cs_rise), .shift_in(ctl_ev[0].rise),
   .run(frame_run), .cnt(frame_cnt));

// File: tb/sim_spx_expander.sv
module sim_spx_expander;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        sclk, sel_n, mosi, en;
   logic [11:0] ext;
   logic [11:0] pin_in;
   logic        miso, miso_oe;
   logic [11:0] drive_low;

   int checks = 0;
   int failures = 0;
   logic [11:0] m_latch = 12'hFFF;
   logic [11:0] m_in = 12'h000;

   always #4 clk = ~clk;

   assign pin_in = ext & ~drive_low;

   spx_expander u0 (
      .sys_clk(clk), .sys_rst_n(rst_n), .host_sclk(sclk), .host_sel_n(sel_n),
      .host_mosi(mosi), .port_en(en), .pin_in(pin_in), .host_miso(miso),
      .host_miso_oe(miso_oe), .pin_drive_low(drive_low));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic release_sel(input string req);
      sel_n = 1'b1;
      tick(8);
      m_latch = m_in;
      chk(drive_low === ~m_latch, req, {20'd0, drive_low}, {20'd0, ~m_latch});
   endtask

   // nbits shift clocks; select rises after rise_at bits (-1: after the loop)
   task automatic run_frame(input logic [11:0] tx, input int nbits, input int rise_at, input logic [11:0] extv);
      logic [11:0] cap;
      ext = extv;
      tick(4);
      cap = extv & m_latch;
      sel_n = 1'b0;
      tick(8);
      chk(miso_oe === 1'b0, "R8 no drive before first clock", {31'd0, miso_oe}, 32'd0);
      for (int b = 0; b < nbits; b++) begin
         if (b == rise_at) release_sel("R6 early release latch");
         sclk = 1'b0;
         mosi = tx[b];
         tick(8);
         chk(miso_oe === 1'b1 && miso === cap[b],
             (rise_at >= 0 && b >= rise_at) ? "R6 readback continues" : "R3 R2 R9 readback bit",
             {30'd0, miso_oe, miso}, {30'd0, 1'b1, cap[b]});
         sclk = 1'b1;
         tick(8);
         m_in = {tx[b], m_in[11:1]};
      end
      if (nbits == 12) begin
         sclk = 1'b0;
         mosi = ~mosi;
         tick(8);
         chk(miso_oe === 1'b0, "R5 floated after last bit", {31'd0, miso_oe}, 32'd0);
         sclk = 1'b1;
         tick(8);
      end
      if (rise_at < 0) release_sel("R4 latch after release");
   endtask

   initial begin
      rst_n = 1'b0; sclk = 1'b1; sel_n = 1'b1; mosi = 1'b0; en = 1'b1; ext = 12'hFFF;
      tick(5);
      rst_n = 1'b1;
      tick(5);
      chk(drive_low === 12'h000, "R1 pins released", {20'd0, drive_low}, 32'd0);
      chk(miso_oe === 1'b0, "R1 R8 serial output idle", {31'd0, miso_oe}, 32'd0);

      // R3 R4 R2: full frames, readback is wired-AND of pins and latch
      for (int i = 0; i < 8; i++) begin
         run_frame(12'(i * 2469 + 5), 12, -1, 12'(~(i * 37)));
      end

      // R7: disable floats outputs, latch preserved
      en = 1'b0;
      tick(2);
      chk(drive_low === 12'h000 && miso_oe === 1'b0, "R7 floated while disabled",
          {19'd0, miso_oe, drive_low}, 32'd0);
      en = 1'b1;
      tick(2);
      chk(drive_low === ~m_latch, "R7 latch kept", {20'd0, drive_low}, {20'd0, ~m_latch});

      // R6: early release after k bits
      for (int k = 1; k < 12; k++) begin
         run_frame(12'(k * 1117 + 3), 12, k, 12'(k * 291));
      end

      // R9: short frames followed by a restarting frame
      run_frame(12'hA5C, 3, -1, 12'hFFF);
      run_frame(12'h3C1, 7, -1, 12'hF0F);
      run_frame(12'h0F3, 12, -1, 12'hFFF);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule